// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. Each cycle it presents the program counter on an instruction read port, decodes the returned 32-bit word, reads up to two operands from a 32-entry register file and evaluates them in an ALU. It then either reads or writes a word on a separate data memory port and commits a result to the register file. The next program counter is chosen by the end of the same cycle.

The core runs nine operations: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an unconditional jump. Three 32-bit word layouts are used. The register form has the opcode in [31:26], first source in [25:21], second source in [20:16], destination in [15:11], a shift field in [10:6] that the core does not use, and the function code in [5:0]. The immediate form has the opcode, two register fields and a 16-bit signed immediate in [15:0]. The jump form has a 26-bit target in [25:0]. Instruction and data memories are external and respond without latency: a read value depends only on the address driven in the same cycle.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0. While `rst` is high, `dmem_we` stays low and no register is written.
- R2: An instruction that is neither a taken branch nor a jump makes `imem_addr` advance by 4 at the next edge.
- R3: The register file has 32 registers of 32 bits. Register 0 always reads as zero, and a write aimed at register 0 is discarded.
- R4: Load (opcode 35) drives `dmem_addr` with the first source plus the sign-extended immediate, and writes `dmem_rdata` to the register in [20:16].
- R5: Store (opcode 43) raises `dmem_we`, forms its address the same way as a load, drives the register in [20:16] on `dmem_wdata`, and writes no register. No other opcode raises `dmem_we`.
- R6: Opcode 0 with function code 32 writes the wrapping sum, and with function code 34 the wrapping difference (first minus second), to the register in [15:11].
- R7: Opcode 0 with function code 36 writes the bitwise and, and with function code 37 the bitwise or, of the two sources to the register in [15:11].
- R8: Opcode 0 with function code 42 writes 1 to the register in [15:11] when the first source is less than the second as signed two's-complement values, and 0 otherwise.
- R9: Branch (opcode 4) sets the next program counter to PC+4 plus the sign-extended immediate shifted left by two when both sources are equal, and to PC+4 otherwise. Negative offsets branch backward.
- R10: Jump (opcode 2) sets the next program counter to bits [31:28] of PC+4, followed by the 26-bit target field and two zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_data | input | 32 | Instruction word read at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or a store |
| dmem_wdata | output | 32 | Word to be stored |
| dmem_rdata | input | 32 | Word read at `dmem_addr` |
| dmem_we | output | 1 | Data memory write strobe, one word on the rising edge |

## Verification
The assertions assume that `imem_data` is a function of `imem_addr` within the same cycle. They also assume that nothing but the core writes the data memory, so that a load returns the most recent store to that address. The bench meets both conditions by serving its instruction and data arrays combinationally from the core's own addresses and by updating its data array only on `dmem_we`. The program uses only the nine supported encodings with word-aligned addresses. It ends in a backward branch to itself, so the instruction port never leaves the loaded region.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_JMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_LOAD = 6'd35;
  localparam logic [5:0] OPC_STOR = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;   // commit a register result
    logic    dst_rd;   // destination from [15:11] instead of [20:16]
    logic    src_imm;  // second ALU operand is the immediate
    logic    wb_mem;   // register result comes from data memory
    logic    mem_we;   // store
    logic    is_beq;
    logic    is_jmp;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq_pc,
                                                  input logic [15:0] imm);
    return seq_pc + {sext16(imm)[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq_pc,
                                                input logic [25:0] tgt);
    return {seq_pc[XLEN-1:XLEN-4], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
      end
      OPC_STOR: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.is_beq = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OPC_JMP: ctl.is_jmp = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int REG_N  = 32,
  parameter int DATA_W = 32,
  parameter int RD_N   = 2,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [IDX_W-1:0]              waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [RD_N-1:0][IDX_W-1:0]    raddr,
  output logic [RD_N-1:0][DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] cells [REG_N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) cells[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_N; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : cells[raddr[p]];
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int REG_N = 32,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        dmem_we
);

  logic [XLEN-1:0] pc_q, pc_seq, pc_next;
  ctrl_t           ctl;

  logic [IDX_W-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
  logic [1:0][IDX_W-1:0] rd_addrs;
  logic [1:0][XLEN-1:0]  rd_vals;
  logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, wb_val;
  logic            alu_zero, rf_we, take_br;

  assign rs_idx = imem_data[21 +: IDX_W];
  assign rt_idx = imem_data[16 +: IDX_W];
  assign rd_idx = imem_data[11 +: IDX_W];

  sc_ctrl u_ctrl (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctl    (ctl)
  );

  assign rd_addrs = {rt_idx, rs_idx};
  assign rs_val   = rd_vals[0];
  assign rt_val   = rd_vals[1];

  sc_regfile #(.REG_N(REG_N), .DATA_W(XLEN), .RD_N(2)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (wb_idx),
    .wdata (wb_val),
    .raddr (rd_addrs),
    .rdata (rd_vals)
  );

  assign imm_x = sext16(imem_data[15:0]);
  assign alu_b = ctl.src_imm ? imm_x : rt_val;

  sc_alu u_alu (
    .op   (ctl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // writeback selection
  assign wb_idx = ctl.dst_rd ? rd_idx : rt_idx;
  assign wb_val = ctl.wb_mem ? dmem_rdata : alu_y;
  assign rf_we  = ctl.reg_we & ~rst;

  // data memory port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we & ~rst;

  // next program counter
  assign pc_seq  = pc_q + XLEN'(4);
  assign take_br = ctl.is_beq & alu_zero;

  always_comb begin
    if (ctl.is_jmp)   pc_next = jump_dest(pc_seq, imem_data[25:0]);
    else if (take_br) pc_next = branch_dest(pc_seq, imem_data[15:0]);
    else              pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic [31:0] dmem_addr,
  input logic [31:0] dmem_wdata,
  input logic        dmem_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);

  logic [5:0]  op;
  logic [31:0] imm_w, seq_pc, br_pc, jmp_pc;

  assign op     = imem_data[31:26];
  assign imm_w  = {{16{imem_data[15]}}, imem_data[15:0]};
  assign seq_pc = imem_addr + 32'd4;
  assign br_pc  = seq_pc + {imm_w[29:0], 2'b00};
  assign jmp_pc = {seq_pc[31:28], imem_data[25:0], 2'b00};

  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == 32'd0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> !dmem_we);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'd4 && op != 6'd2) |=> (imem_addr == $past(seq_pc)));

  p_zero_reg_r3: assert property (@(posedge clk) disable iff (rst)
    (imem_data[25:21] == 5'd0) |-> (rs_val == 32'd0));

  p_mem_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd35 || op == 6'd43) |-> (dmem_addr == rs_val + imm_w));

  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd43) |-> (dmem_we && dmem_wdata == rt_val));

  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (op == 6'd43));

  p_beq_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && rs_val == rt_val) |=> (imem_addr == $past(br_pc)));

  p_beq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && rs_val != rt_val) |=> (imem_addr == $past(seq_pc)));

  p_jump_r10: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> (imem_addr == $past(jmp_pc)));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_data  (imem_data),
  .dmem_addr  (dmem_addr),
  .dmem_wdata (dmem_wdata),
  .dmem_we    (dmem_we),
  .rs_val     (rs_val),
  .rt_val     (rt_val)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

  localparam int CLK_NS = 10;
  localparam int MEM_W  = 32;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } store_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [MEM_W];
  logic [31:0] dmem [MEM_W];

  store_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  int n_stores = 0;

  always #(CLK_NS/2) clk = ~clk;

  sc_core u0 (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .dmem_we    (dmem_we)
  );

  assign imem_data  = imem[imem_addr[6:2]];
  assign dmem_rdata = dmem[dmem_addr[6:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[6:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_store(logic [31:0] a, logic [31:0] d, string tag);
    store_t s;
    s.addr = a; s.data = d; s.tag = tag;
    sb_q.push_back(s);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      n_stores++;
      if (sb_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R9/R10 unexpected store: actual %h@%h expected none",
                 dmem_wdata, dmem_addr);
      end else begin
        store_t s;
        s = sb_q.pop_front();
        check({s.tag, " store address"}, dmem_addr, s.addr);
        check({s.tag, " store data"}, dmem_wdata, s.data);
      end
    end
  end

  task automatic load_program();
    for (int k = 0; k < MEM_W; k++) begin
      imem[k] = 32'd0;
      dmem[k] = 32'd0;
    end
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'd7;
    dmem[3] = 32'd48;
    imem[0]  = enc_i(6'd35, 0, 1, 16'd0);      // r1 = 5
    imem[1]  = enc_i(6'd35, 0, 2, 16'd4);      // r2 = -3
    imem[2]  = enc_i(6'd35, 0, 3, 16'd8);      // r3 = 7
    imem[3]  = enc_i(6'd35, 0, 10, 16'd12);    // r10 = 48
    imem[4]  = enc_r(1, 2, 4, 6'd32);          // add
    imem[5]  = enc_i(6'd43, 0, 4, 16'd16);
    imem[6]  = enc_r(1, 3, 5, 6'd34);          // sub
    imem[7]  = enc_i(6'd43, 0, 5, 16'd20);
    imem[8]  = enc_r(1, 3, 6, 6'd36);          // and
    imem[9]  = enc_i(6'd43, 0, 6, 16'd24);
    imem[10] = enc_r(1, 2, 7, 6'd37);          // or
    imem[11] = enc_i(6'd43, 0, 7, 16'd28);
    imem[12] = enc_r(2, 1, 8, 6'd42);          // -3 < 5
    imem[13] = enc_i(6'd43, 0, 8, 16'd32);
    imem[14] = enc_r(1, 2, 9, 6'd42);          // 5 < -3
    imem[15] = enc_i(6'd43, 0, 9, 16'd36);
    imem[16] = enc_r(1, 1, 0, 6'd32);          // write to r0
    imem[17] = enc_i(6'd43, 0, 0, 16'd40);
    imem[18] = enc_i(6'd43, 10, 1, 16'hFFFC);  // negative displacement
    imem[19] = enc_i(6'd4, 1, 2, 16'd1);       // not taken
    imem[20] = enc_i(6'd43, 0, 2, 16'd48);
    imem[21] = enc_i(6'd4, 1, 1, 16'd1);       // taken
    imem[22] = enc_i(6'd43, 0, 1, 16'd52);     // skipped
    imem[23] = enc_i(6'd43, 0, 3, 16'd56);
    imem[24] = enc_j(26'd26);
    imem[25] = enc_i(6'd43, 0, 1, 16'd60);     // skipped
    imem[26] = enc_i(6'd35, 0, 12, 16'd16);    // read back stored sum
    imem[27] = enc_i(6'd43, 0, 12, 16'd68);
    imem[28] = enc_i(6'd4, 0, 0, 16'hFFFF);    // branch to itself
  endtask

  initial begin
    load_program();
    expect_store(32'd16, 32'd2,          "R4/R5/R6 add");
    expect_store(32'd20, 32'hFFFF_FFFE,  "R6 sub");
    expect_store(32'd24, 32'd5,          "R7 and");
    expect_store(32'd28, 32'hFFFF_FFFD,  "R7 or");
    expect_store(32'd32, 32'd1,          "R8 slt true");
    expect_store(32'd36, 32'd0,          "R8 slt false");
    expect_store(32'd40, 32'd0,          "R3 r0 write ignored");
    expect_store(32'd44, 32'd5,          "R4 negative displacement");
    expect_store(32'd48, 32'hFFFF_FFFD,  "R9 not taken");
    expect_store(32'd56, 32'd7,          "R9 taken");
    expect_store(32'd68, 32'd2,          "R10 jump target");

    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 pc in reset", imem_addr, 32'd0);
      check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    end
    rst = 1'b0;
    check("R2 first fetch", imem_addr, 32'd0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check("R2 sequential fetch", imem_addr, 32'(k * 4));
    end

    begin
      int wd;
      wd = 0;
      while (sb_q.size() != 0 && wd < 500) begin
        @(negedge clk);
        wd++;
      end
      if (wd >= 500) begin
        n_checks++;
        n_errors++;
        $display("FAIL R5 watchdog: actual %0d stores pending expected 0", sb_q.size());
      end
    end

    repeat (6) @(negedge clk);
    check("R9 backward self-branch pc", imem_addr, 32'd112);
    @(negedge clk);
    check("R9 pc holds on self-branch", imem_addr, 32'd112);
    check("R5 total store count", 32'(n_stores), 32'd11);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule